// File: doc/BRIEF.md
# Privileged Trap-Return Unit

This unit carries out the two privileged return instructions of a RISC-V-style core: the return from a supervisor trap handler and the return from a machine trap handler. The hypervisor extension is optional. Each request reports which of the two returns it is. It also carries the hart's current privilege level, its virtualization flag, the relevant status and hypervisor-status bits, both saved exception PCs, and flags that say whether the compressed, hypervisor and memory-protection features are present. The unit decides whether the return is legal.

One clock edge after a request, the unit gives one of two results. An illegal return gives an exception strobe and a cause code. A legal return gives a commit strobe with the target PC, the next privilege level, the next virtualization flag and the rewritten status bits. It also raises a strobe when the surrounding core must swap its banked hypervisor registers.

The unit keeps no copy of the register file. The core writes the unit's field outputs back into its status registers when it sees the commit strobe.

Top module: `tret_unit`

## Requirements
- R1: A supervisor return requested while the current privilege is user (encoding 2'b00) raises cause 2 (illegal instruction). This check has priority over every other check.
- R2: A machine return requested at any privilege other than machine (2'b11) raises cause 2. This check has priority over every other check.
- R3: The privilege check comes first. If it passes, and the compressed feature is absent while bits [1:0] of the selected saved PC (sepc for a supervisor return, mepc for a machine return) are nonzero, the unit raises cause 0 (misaligned fetch). This check takes priority over R4, R5 and R9.
- R4: A supervisor return with the trap-supervisor-return bit set raises cause 2 if the current privilege is not machine. From machine privilege, the return proceeds.
- R5: With the hypervisor feature present, virtualization on and the virtual trap-supervisor-return bit set, an otherwise legal supervisor return raises cause 22 (virtual instruction). Without the hypervisor feature, that bit has no effect.
- R6: A legal supervisor return copies the supervisor previous-interrupt-enable bit into the supervisor interrupt enable, sets that previous-enable bit to 1, and clears the supervisor previous-privilege bit. The next privilege is user when the old bit was 0 and supervisor (2'b01) when it was 1. The machine fields pass through unchanged.
- R7: A legal supervisor return with the hypervisor feature present and virtualization off takes the next virtualization flag from the hypervisor previous-virtualization bit and clears that bit. It requests a register swap when the old bit was 1. In every other case the virtualization flag is kept, that bit is untouched and no swap is requested.
- R8: A legal machine return copies the machine previous-interrupt-enable bit into the machine interrupt enable and sets that previous-enable bit to 1. It sets the machine previous privilege to user, takes the next privilege from the old value of that field, and clears the machine previous-virtualization bit. With the hypervisor feature present, the next virtualization flag is the old previous-virtualization bit and a swap is requested when that bit was 1. Without the feature, the flag is kept. The supervisor fields pass through unchanged.
- R9: A machine return whose previous privilege is not machine raises cause 2 when memory protection is implemented and the configured rule count is zero.
- R10: A request with reqValid high at one rising edge produces its result at that same edge, seen by the core during the following cycle. On a commit, retPc is sepc for a supervisor return (isMret=0) and mepc for a machine return (isMret=1). doneValid and swapNeeded stay high for only that one cycle.
- R11: An illegal return raises excValid for exactly the one cycle after the request, keeps doneValid low, and leaves retPc, the privilege, the virtualization flag and every status output at its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Return request this cycle |
| isMret | input | 1 | 1 = machine return, 0 = supervisor return |
| curPriv | input | 2 | Current privilege (U=00, S=01, M=11) |
| curVirt | input | 1 | Current virtualization flag |
| extC | input | 1 | Compressed instructions present |
| extH | input | 1 | Hypervisor feature present |
| pmpOn | input | 1 | Memory protection implemented |
| pmpRuleCnt | input | PMP_CNT_W | Number of configured protection rules |
| sieIn | input | 1 | Supervisor interrupt enable |
| spieIn | input | 1 | Supervisor previous interrupt enable |
| sppIn | input | 1 | Supervisor previous privilege |
| mieIn | input | 1 | Machine interrupt enable |
| mpieIn | input | 1 | Machine previous interrupt enable |
| mppIn | input | 2 | Machine previous privilege |
| mpvIn | input | 1 | Machine previous virtualization |
| tsrIn | input | 1 | Trap supervisor return |
| spvIn | input | 1 | Hypervisor previous virtualization |
| vtsrIn | input | 1 | Virtual trap supervisor return |
| sepc | input | XLEN | Saved supervisor exception PC |
| mepc | input | XLEN | Saved machine exception PC |
| doneValid | output | 1 | Legal return committed (one cycle) |
| retPc | output | XLEN | Return target PC |
| newPriv | output | 2 | Next privilege |
| newVirt | output | 1 | Next virtualization flag |
| sieOut | output | 1 | Updated supervisor interrupt enable |
| spieOut | output | 1 | Updated supervisor previous enable |
| sppOut | output | 1 | Updated supervisor previous privilege |
| mieOut | output | 1 | Updated machine interrupt enable |
| mpieOut | output | 1 | Updated machine previous enable |
| mppOut | output | 2 | Updated machine previous privilege |
| mpvOut | output | 1 | Updated machine previous virtualization |
| spvOut | output | 1 | Updated hypervisor previous virtualization |
| swapNeeded | output | 1 | Banked hypervisor registers must be swapped |
| excValid | output | 1 | Return rejected (one cycle) |
| excCode | output | 5 | Cause of the rejection |

## Verification
A table drives both return kinds from every privilege level, with the compressed, hypervisor and protection flags switched on and off. This tells the privilege faults apart from the misalignment, trap-return and virtual faults. Some rows set two fault conditions at once to confirm which one wins. Pairs of rows that differ only in the hypervisor flag or the previous-virtualization bit separate restoring the virtualization flag from keeping it. Directed cases then check the bit updates of each return and that a rejected return leaves all outputs unchanged.

// File: rtl/tret_pkg.sv
package tret_pkg;
  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam int unsigned CODE_W = 5;
  localparam logic [CODE_W-1:0] EXC_FETCH_MISALIGN = 5'd0;
  localparam logic [CODE_W-1:0] EXC_ILLEGAL        = 5'd2;
  localparam logic [CODE_W-1:0] EXC_VIRT_INSN      = 5'd22;

  // strobes from the decision logic to the state datapath
  typedef struct packed {
    logic commit;     // legal return: load the new state
    logic isMret;     // which return is being committed
    logic hvRestore;  // restore virtualization from the saved bit
  } tret_strobe_t;
endpackage

// File: rtl/tret_ctrl.sv
module tret_ctrl
  import tret_pkg::*;
#(
  parameter int unsigned PMP_CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 isMret,
  input  logic [1:0]           curPriv,
  input  logic                 curVirt,
  input  logic                 extC,
  input  logic                 extH,
  input  logic                 pmpOn,
  input  logic [PMP_CNT_W-1:0] pmpRuleCnt,
  input  logic                 tsrIn,
  input  logic                 vtsrIn,
  input  logic [1:0]           mppIn,
  input  logic [1:0]           sepcLow,
  input  logic [1:0]           mepcLow,
  output tret_strobe_t         stb,
  output logic                 excValid,
  output logic [CODE_W-1:0]    excCode
);
  logic              fault;
  logic [CODE_W-1:0] faultCode;
  logic [1:0]        pcLow;
  logic              misaligned;

  assign pcLow      = isMret ? mepcLow : sepcLow;
  assign misaligned = !extC && (pcLow != 2'b00);

  // ordered legality checks; first hit wins
  always_comb begin
    fault     = 1'b0;
    faultCode = EXC_ILLEGAL;
    if (!isMret) begin
      if (curPriv < PRIV_S) begin
        fault = 1'b1;
      end else if (misaligned) begin
        fault     = 1'b1;
        faultCode = EXC_FETCH_MISALIGN;
      end else if (tsrIn && curPriv != PRIV_M) begin
        fault = 1'b1;
      end else if (extH && curVirt && vtsrIn) begin
        fault     = 1'b1;
        faultCode = EXC_VIRT_INSN;
      end
    end else begin
      if (curPriv != PRIV_M) begin
        fault = 1'b1;
      end else if (misaligned) begin
        fault     = 1'b1;
        faultCode = EXC_FETCH_MISALIGN;
      end else if (pmpOn && pmpRuleCnt == '0 && mppIn != PRIV_M) begin
        fault = 1'b1;
      end
    end
  end

  assign stb.commit    = reqValid && !fault;
  assign stb.isMret    = isMret;
  assign stb.hvRestore = extH && (isMret || !curVirt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excValid <= 1'b0;
      excCode  <= '0;
    end else begin
      excValid <= reqValid && fault;
      if (reqValid && fault) excCode <= faultCode;
    end
  end

  p_sret_low_priv_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !isMret && curPriv == PRIV_U |=> excValid && excCode == EXC_ILLEGAL);

  p_mret_low_priv_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && isMret && curPriv != PRIV_M |=> excValid && excCode == EXC_ILLEGAL);

  p_mret_misalign_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && isMret && curPriv == PRIV_M && !extC && mepcLow != 2'b00
    |=> excValid && excCode == EXC_FETCH_MISALIGN);

  p_no_rules_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && isMret && curPriv == PRIV_M && (extC || mepcLow == 2'b00) &&
    pmpOn && pmpRuleCnt == '0 && mppIn != PRIV_M
    |=> excValid && excCode == EXC_ILLEGAL);

  p_exc_from_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> $past(reqValid));
endmodule

// File: rtl/tret_dpath.sv
module tret_dpath
  import tret_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  tret_strobe_t    stb,
  input  logic            curVirt,
  input  logic            sieIn,
  input  logic            spieIn,
  input  logic            sppIn,
  input  logic            mieIn,
  input  logic            mpieIn,
  input  logic [1:0]      mppIn,
  input  logic            mpvIn,
  input  logic            spvIn,
  input  logic [XLEN-1:0] sepc,
  input  logic [XLEN-1:0] mepc,
  output logic            doneValid,
  output logic [XLEN-1:0] retPc,
  output logic [1:0]      newPriv,
  output logic            newVirt,
  output logic            sieOut,
  output logic            spieOut,
  output logic            sppOut,
  output logic            mieOut,
  output logic            mpieOut,
  output logic [1:0]      mppOut,
  output logic            mpvOut,
  output logic            spvOut,
  output logic            swapNeeded
);
  logic [XLEN-1:0] nPc;
  logic [1:0]      nPriv, nMpp;
  logic            nVirt, nSie, nSpie, nSpp, nMie, nMpie, nMpv, nSpv, nSwap;

  always_comb begin
    nSie  = sieIn;  nSpie = spieIn; nSpp = sppIn;
    nMie  = mieIn;  nMpie = mpieIn; nMpp = mppIn;
    nMpv  = mpvIn;  nSpv  = spvIn;
    nVirt = curVirt;
    nSwap = 1'b0;
    if (stb.isMret) begin
      nPc   = mepc;
      nPriv = mppIn;
      nMie  = mpieIn;
      nMpie = 1'b1;
      nMpp  = PRIV_U;
      nMpv  = 1'b0;
      if (stb.hvRestore) begin
        nVirt = mpvIn;
        nSwap = mpvIn;
      end
    end else begin
      nPc   = sepc;
      nPriv = {1'b0, sppIn};
      nSie  = spieIn;
      nSpie = 1'b1;
      nSpp  = 1'b0;
      if (stb.hvRestore) begin
        nVirt = spvIn;
        nSpv  = 1'b0;
        nSwap = spvIn;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid  <= 1'b0;
      swapNeeded <= 1'b0;
      retPc      <= '0;
      newPriv    <= PRIV_U;
      newVirt    <= 1'b0;
      sieOut     <= 1'b0;
      spieOut    <= 1'b0;
      sppOut     <= 1'b0;
      mieOut     <= 1'b0;
      mpieOut    <= 1'b0;
      mppOut     <= PRIV_U;
      mpvOut     <= 1'b0;
      spvOut     <= 1'b0;
    end else begin
      doneValid  <= stb.commit;
      swapNeeded <= stb.commit && nSwap;
      if (stb.commit) begin
        retPc   <= nPc;
        newPriv <= nPriv;
        newVirt <= nVirt;
        sieOut  <= nSie;
        spieOut <= nSpie;
        sppOut  <= nSpp;
        mieOut  <= nMie;
        mpieOut <= nMpie;
        mppOut  <= nMpp;
        mpvOut  <= nMpv;
        spvOut  <= nSpv;
      end
    end
  end

  p_hold_state_r11: assert property (@(posedge clk) disable iff (!rstN)
    !doneValid |-> $stable(retPc) && $stable(newPriv) && $stable(newVirt) && $stable(mppOut));

  p_sret_fields_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && !$past(stb.isMret) |-> spieOut && !sppOut);

  p_mret_fields_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && $past(stb.isMret) |-> mpieOut && !mpvOut && mppOut == PRIV_U);

  p_swap_with_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    swapNeeded |-> doneValid);
endmodule

// File: rtl/tret_unit.sv
module tret_unit
  import tret_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned PMP_CNT_W = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 isMret,
  input  logic [1:0]           curPriv,
  input  logic                 curVirt,
  input  logic                 extC,
  input  logic                 extH,
  input  logic                 pmpOn,
  input  logic [PMP_CNT_W-1:0] pmpRuleCnt,
  input  logic                 sieIn,
  input  logic                 spieIn,
  input  logic                 sppIn,
  input  logic                 mieIn,
  input  logic                 mpieIn,
  input  logic [1:0]           mppIn,
  input  logic                 mpvIn,
  input  logic                 tsrIn,
  input  logic                 spvIn,
  input  logic                 vtsrIn,
  input  logic [XLEN-1:0]      sepc,
  input  logic [XLEN-1:0]      mepc,
  output logic                 doneValid,
  output logic [XLEN-1:0]      retPc,
  output logic [1:0]           newPriv,
  output logic                 newVirt,
  output logic                 sieOut,
  output logic                 spieOut,
  output logic                 sppOut,
  output logic                 mieOut,
  output logic                 mpieOut,
  output logic [1:0]           mppOut,
  output logic                 mpvOut,
  output logic                 spvOut,
  output logic                 swapNeeded,
  output logic                 excValid,
  output logic [CODE_W-1:0]    excCode
);
  tret_strobe_t stb;

  tret_ctrl #(.PMP_CNT_W(PMP_CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isMret(isMret),
    .curPriv(curPriv), .curVirt(curVirt), .extC(extC), .extH(extH),
    .pmpOn(pmpOn), .pmpRuleCnt(pmpRuleCnt), .tsrIn(tsrIn), .vtsrIn(vtsrIn),
    .mppIn(mppIn), .sepcLow(sepc[1:0]), .mepcLow(mepc[1:0]),
    .stb(stb), .excValid(excValid), .excCode(excCode)
  );

  tret_dpath #(.XLEN(XLEN)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .curVirt(curVirt),
    .sieIn(sieIn), .spieIn(spieIn), .sppIn(sppIn), .mieIn(mieIn),
    .mpieIn(mpieIn), .mppIn(mppIn), .mpvIn(mpvIn), .spvIn(spvIn),
    .sepc(sepc), .mepc(mepc),
    .doneValid(doneValid), .retPc(retPc), .newPriv(newPriv), .newVirt(newVirt),
    .sieOut(sieOut), .spieOut(spieOut), .sppOut(sppOut), .mieOut(mieOut),
    .mpieOut(mpieOut), .mppOut(mppOut), .mpvOut(mpvOut), .spvOut(spvOut),
    .swapNeeded(swapNeeded)
  );

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(excValid && doneValid));
endmodule

// File: tb/tret_unit_tb_top.sv
module tret_unit_tb_top;
  localparam int unsigned XLEN = 32;
  localparam int unsigned PW   = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, isMret = 0, curVirt = 0, extC = 0, extH = 0, pmpOn = 0;
  logic [1:0] curPriv = 0, mppIn = 0;
  logic [PW-1:0] pmpRuleCnt = 0;
  logic sieIn = 0, spieIn = 0, sppIn = 0, mieIn = 0, mpieIn = 0, mpvIn = 0;
  logic tsrIn = 0, spvIn = 0, vtsrIn = 0;
  logic [XLEN-1:0] sepc = 0, mepc = 0;
  logic doneValid, newVirt, sieOut, spieOut, sppOut, mieOut, mpieOut, mpvOut, spvOut;
  logic swapNeeded, excValid;
  logic [XLEN-1:0] retPc;
  logic [1:0] newPriv, mppOut;
  logic [4:0] excCode;

  int checkCnt = 0;
  int failCnt  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tret_unit #(.XLEN(XLEN), .PMP_CNT_W(PW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .isMret(isMret),
    .curPriv(curPriv), .curVirt(curVirt), .extC(extC), .extH(extH),
    .pmpOn(pmpOn), .pmpRuleCnt(pmpRuleCnt), .sieIn(sieIn), .spieIn(spieIn),
    .sppIn(sppIn), .mieIn(mieIn), .mpieIn(mpieIn), .mppIn(mppIn), .mpvIn(mpvIn),
    .tsrIn(tsrIn), .spvIn(spvIn), .vtsrIn(vtsrIn), .sepc(sepc), .mepc(mepc),
    .doneValid(doneValid), .retPc(retPc), .newPriv(newPriv), .newVirt(newVirt),
    .sieOut(sieOut), .spieOut(spieOut), .sppOut(sppOut), .mieOut(mieOut),
    .mpieOut(mpieOut), .mppOut(mppOut), .mpvOut(mpvOut), .spvOut(spvOut),
    .swapNeeded(swapNeeded), .excValid(excValid), .excCode(excCode)
  );

  typedef struct packed {
    logic [7:0] req;
    logic       isM;
    logic [1:0] priv;
    logic       virt, c, h, pmp;
    logic [3:0] rules;
    logic       tsr, vtsr, spp, spv;
    logic [1:0] mpp;
    logic       mpv;
    logic [1:0] pcLo;
    logic       expExc;
    logic [4:0] expCode;
    logic [1:0] expPriv;
    logic       expVirt, expSwap;
  } vec_t;

  localparam int NVEC = 18;
  // req isM priv virt c h pmp rules tsr vtsr spp spv mpp mpv pcLo | exc code priv virt swap
  localparam vec_t VECS [NVEC] = '{
    '{8'd1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'd0, 1'b1, 5'd2,  2'b00, 1'b0, 1'b0}, // R1
    '{8'd2, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 2'd0, 1'b1, 5'd2,  2'b00, 1'b0, 1'b0}, // R2
    '{8'd3, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'd2, 1'b1, 5'd0,  2'b00, 1'b0, 1'b0}, // R3
    '{8'd3, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'd2, 1'b0, 5'd0,  2'b00, 1'b0, 1'b0}, // R3
    '{8'd4, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'd0, 1'b1, 5'd2,  2'b00, 1'b0, 1'b0}, // R4
    '{8'd4, 1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 2'd0, 1'b0, 5'd0,  2'b01, 1'b0, 1'b0}, // R4
    '{8'd5, 1'b0, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'd0, 1'b1, 5'd22, 2'b00, 1'b0, 1'b0}, // R5
    '{8'd7, 1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 2'd0, 1'b0, 5'd0,  2'b01, 1'b1, 1'b1}, // R7
    '{8'd7, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 2'd0, 1'b0, 5'd0,  2'b00, 1'b0, 1'b0}, // R7
    '{8'd9, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 2'd0, 1'b1, 5'd2,  2'b00, 1'b0, 1'b0}, // R9
    '{8'd9, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 2'd0, 1'b0, 5'd0,  2'b11, 1'b0, 1'b0}, // R9
    '{8'd8, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 2'd0, 1'b0, 5'd0,  2'b00, 1'b1, 1'b1}, // R8
    '{8'd8, 1'b1, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 1'b1, 2'd0, 1'b0, 5'd0,  2'b01, 1'b0, 1'b0}, // R8
    '{8'd1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'd1, 1'b1, 5'd2,  2'b00, 1'b0, 1'b0}, // R1 beats R3
    '{8'd3, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'd3, 1'b1, 5'd0,  2'b00, 1'b0, 1'b0}, // R3 beats R9
    '{8'd3, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 2'd2, 1'b1, 5'd0,  2'b00, 1'b0, 1'b0}, // R3 beats R4
    '{8'd5, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 2'd0, 1'b0, 5'd0,  2'b00, 1'b1, 1'b0}, // R5 no H
    '{8'd7, 1'b0, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 2'd0, 1'b0, 5'd0,  2'b00, 1'b1, 1'b0}  // R7 virt on
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // call right after a negedge with inputs set; returns at the next negedge
  task automatic fire();
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] keepPc;
    repeat (3) @(negedge clk);
    // reset state
    check("R10", "reset doneValid", {31'd0, doneValid}, 0);
    check("R11", "reset excValid", {31'd0, excValid}, 0);
    check("R10", "reset retPc", retPc, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      vec_t v;
      v = VECS[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      isMret = v.isM; curPriv = v.priv; curVirt = v.virt; extC = v.c; extH = v.h;
      pmpOn = v.pmp; pmpRuleCnt = {1'b0, v.rules}; tsrIn = v.tsr; vtsrIn = v.vtsr;
      sppIn = v.spp; spvIn = v.spv; mppIn = v.mpp; mpvIn = v.mpv;
      sepc = 32'h1000_0000 | {30'd0, v.pcLo};
      mepc = 32'h2000_0000 | {30'd0, v.pcLo};
      fire();
      check(tag, "excValid", {31'd0, excValid}, {31'd0, v.expExc});
      check(tag, "doneValid", {31'd0, doneValid}, {31'd0, !v.expExc});
      if (v.expExc) begin
        check(tag, "excCode", {27'd0, excCode}, {27'd0, v.expCode});
      end else begin
        check(tag, "retPc", retPc, v.isM ? mepc : sepc);
        check(tag, "newPriv", {30'd0, newPriv}, {30'd0, v.expPriv});
        check(tag, "newVirt", {31'd0, newVirt}, {31'd0, v.expVirt});
        check(tag, "swapNeeded", {31'd0, swapNeeded}, {31'd0, v.expSwap});
      end
    end

    // R6: supervisor return field updates, machine fields untouched
    @(negedge clk);
    isMret = 0; curPriv = 2'b01; curVirt = 0; extC = 1; extH = 0; pmpOn = 0; tsrIn = 0;
    sieIn = 1; spieIn = 0; sppIn = 1; mieIn = 1; mpieIn = 0; mppIn = 2'b01; mpvIn = 1;
    sepc = 32'h0000_4444;
    fire();
    check("R6", "sieOut", {31'd0, sieOut}, 0);
    check("R6", "spieOut", {31'd0, spieOut}, 1);
    check("R6", "sppOut", {31'd0, sppOut}, 0);
    check("R6", "newPriv", {30'd0, newPriv}, 1);
    check("R6", "mieOut kept", {31'd0, mieOut}, 1);
    check("R6", "mppOut kept", {30'd0, mppOut}, 1);
    check("R10", "doneValid pulse", {31'd0, doneValid}, 1);
    @(negedge clk);
    check("R10", "doneValid drops", {31'd0, doneValid}, 0);

    // R8: machine return field updates, supervisor fields untouched
    isMret = 1; curPriv = 2'b11; mieIn = 0; mpieIn = 1; mppIn = 2'b01; mpvIn = 1;
    sieIn = 1; spieIn = 0; sppIn = 1; mepc = 32'h0000_8888;
    fire();
    check("R8", "mieOut", {31'd0, mieOut}, 1);
    check("R8", "mpieOut", {31'd0, mpieOut}, 1);
    check("R8", "mppOut", {30'd0, mppOut}, 0);
    check("R8", "mpvOut", {31'd0, mpvOut}, 0);
    check("R8", "newPriv", {30'd0, newPriv}, 1);
    check("R8", "sieOut kept", {31'd0, sieOut}, 1);
    check("R8", "sppOut kept", {31'd0, sppOut}, 1);
    check("R10", "retPc mepc", retPc, 32'h0000_8888);
    keepPc = retPc;

    // R11: rejected return leaves everything as it was, one-cycle strobe
    isMret = 0; curPriv = 2'b00; sepc = 32'h0000_1230; spieIn = 1; sieIn = 0;
    fire();
    check("R11", "excValid", {31'd0, excValid}, 1);
    check("R11", "doneValid low", {31'd0, doneValid}, 0);
    check("R11", "retPc held", retPc, keepPc);
    check("R11", "sieOut held", {31'd0, sieOut}, 1);
    check("R11", "newPriv held", {30'd0, newPriv}, 1);
    check("R11", "mieOut held", {31'd0, mieOut}, 1);
    @(negedge clk);
    check("R11", "excValid drops", {31'd0, excValid}, 0);

    report();
  end
endmodule